// File: doc/BRIEF.md
# Display Window Scaler and Border

This block sits after a raster timing generator. Each pixel cycle it takes the current column and row and produces the controls that pixel needs: whether the pixel lies inside the programmable display window, and which source pixel coordinates the layer renderers should fetch. The horizontal and vertical axes each have an 8-bit fractional step value. A step of 128 moves one source pixel per output pixel. A step of 64 shows every source pixel twice. Outside the window, the output pixel is replaced by an 8-bit border palette index.

The window edges are coarse. The column edges are stored as 8-bit codes that are multiplied by 4. The row edges are stored as 8-bit codes that are multiplied by 2. A small write-only register file provides four addresses. A bank-select input decides whether a write lands in the scale/border bank or in the window-edge bank. All pixel outputs are registered. They update one clock after a cycle in which `pix_en_i` is high, and they hold their values otherwise.

Top module: `disp_window`

## Requirements
- R1: After reset both step values are 128, the window covers the whole H_ACTIVE x V_ACTIVE area, the border index is 0, and all pixel outputs are 0.
- R2: With `bank_sel_i`=0, a write to address 0 sets the horizontal step, address 1 sets the vertical step, and address 2 sets the border index. With `bank_sel_i`=1, address 0 sets the column start code, 1 the column stop code, 2 the row start code, and 3 the row stop code.
- R3: A pixel is horizontally inside the window when 4*colstart <= column < 4*colstop.
- R4: A pixel is vertically inside the window when 2*rowstart <= row < 2*rowstop. `active_o` is the AND of this condition and R3.
- R5: `pix_o` equals `layer_pix_i` for an active pixel and the border index for any other pixel.
- R6: For an active pixel, `src_x_o` = floor((column - 4*colstart) * hstep / 128). The horizontal accumulator restarts at the start column of every line.
- R7: For an active pixel, `src_y_o` = floor((row - 2*rowstart) * vstep / 128). The vertical accumulator restarts at the start row and advances once per line, at the last column.
- R8: The outputs for a pixel appear on the clock edge that samples it with `pix_en_i`=1. While `pix_en_i`=0 all outputs hold their values.
- R9: A write with `bank_sel_i`=0 to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| bank_sel_i | input | 1 | Bank select for writes |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Write data |
| pix_en_i | input | 1 | Pixel cycle strobe |
| col_i | input | 10 | Raster column |
| row_i | input | 9 | Raster row |
| layer_pix_i | input | 8 | Rendered palette index for the pixel |
| active_o | output | 1 | Pixel is inside the window |
| src_x_o | output | 11 | Source column |
| src_y_o | output | 10 | Source row |
| pix_o | output | 8 | Layer index or border index |

## Verification
The bench builds the block with H_ACTIVE=64 and V_ACTIVE=32. The field widths stay at their defaults, so the coarse edge arithmetic is unchanged. With this small raster every pixel of every frame can be checked against arithmetic expectations. That covers the full-area reset window, offset windows with both steps below 128, a step above 128, a window that is only one row pair tall, and an empty window whose start lies beyond its stop. A complete frame in every configuration means the per-line accumulator restart and the per-frame vertical restart are both exercised many times.

// File: rtl/dw_pkg.sv
package dw_pkg;
  localparam int unsigned CODE_W = 8;

  typedef struct packed {
    logic [CODE_W-1:0] hstep;
    logic [CODE_W-1:0] vstep;
    logic [CODE_W-1:0] border;
    logic [CODE_W-1:0] hstart;
    logic [CODE_W-1:0] hstop;
    logic [CODE_W-1:0] vstart;
    logic [CODE_W-1:0] vstop;
  } dw_cfg_t;

  typedef enum logic [1:0] {
    SLOT_0 = 2'd0,
    SLOT_1 = 2'd1,
    SLOT_2 = 2'd2,
    SLOT_3 = 2'd3
  } dw_slot_e;
endpackage

// File: rtl/dw_regs.sv
module dw_regs
  import dw_pkg::*;
#(
  parameter int unsigned H_STOP_RST = 160,
  parameter int unsigned V_STOP_RST = 240,
  parameter int unsigned STEP_RST   = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              bank_sel_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [CODE_W-1:0] wr_data_i,
  output dw_cfg_t           cfg_o
);
  dw_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.hstep  <= CODE_W'(STEP_RST);
      cfg_q.vstep  <= CODE_W'(STEP_RST);
      cfg_q.border <= '0;
      cfg_q.hstart <= '0;
      cfg_q.hstop  <= CODE_W'(H_STOP_RST);
      cfg_q.vstart <= '0;
      cfg_q.vstop  <= CODE_W'(V_STOP_RST);
    end else if (wr_en_i) begin
      if (!bank_sel_i) begin
        unique case (dw_slot_e'(wr_addr_i))
          SLOT_0:  cfg_q.hstep  <= wr_data_i;
          SLOT_1:  cfg_q.vstep  <= wr_data_i;
          SLOT_2:  cfg_q.border <= wr_data_i;
          default: ;  // unused slot in this bank
        endcase
      end else begin
        unique case (dw_slot_e'(wr_addr_i))
          SLOT_0:  cfg_q.hstart <= wr_data_i;
          SLOT_1:  cfg_q.hstop  <= wr_data_i;
          SLOT_2:  cfg_q.vstart <= wr_data_i;
          default: cfg_q.vstop  <= wr_data_i;
        endcase
      end
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/dw_axis.sv
// One axis: window compare plus fractional source coordinate accumulator.
module dw_axis
  import dw_pkg::*;
#(
  parameter int unsigned SHIFT  = 2,
  parameter int unsigned FRAC_W = 7,
  parameter int unsigned POS_W  = CODE_W + SHIFT,
  parameter int unsigned ACC_W  = POS_W + CODE_W,
  parameter int unsigned SRC_W  = ACC_W - FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [CODE_W-1:0] start_i,
  input  logic [CODE_W-1:0] stop_i,
  input  logic [CODE_W-1:0] step_i,
  output logic              in_win_o,
  output logic [SRC_W-1:0]  src_o
);
  logic [POS_W-1:0] lo, hi;
  logic [ACC_W-1:0] acc_q, acc_cur;

  assign lo       = {start_i, {SHIFT{1'b0}}};
  assign hi       = {stop_i, {SHIFT{1'b0}}};
  assign in_win_o = (pos_i >= lo) && (pos_i < hi);
  assign acc_cur  = (pos_i == lo) ? '0 : acc_q;
  assign src_o    = acc_cur[ACC_W-1:FRAC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                acc_q <= '0;
    else if (adv_i && in_win_o) acc_q <= acc_cur + ACC_W'(step_i);
  end
endmodule

// File: rtl/disp_window.sv
module disp_window
  import dw_pkg::*;
#(
  parameter int unsigned H_ACTIVE = 640,
  parameter int unsigned V_ACTIVE = 480,
  parameter int unsigned H_SHIFT  = 2,
  parameter int unsigned V_SHIFT  = 1,
  parameter int unsigned FRAC_W   = 7
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_en_i,
  input  logic                                bank_sel_i,
  input  logic [1:0]                          wr_addr_i,
  input  logic [dw_pkg::CODE_W-1:0]           wr_data_i,
  input  logic                                pix_en_i,
  input  logic [dw_pkg::CODE_W+H_SHIFT-1:0]   col_i,
  input  logic [dw_pkg::CODE_W+V_SHIFT-1:0]   row_i,
  input  logic [dw_pkg::CODE_W-1:0]           layer_pix_i,
  output logic                                active_o,
  output logic [2*dw_pkg::CODE_W+H_SHIFT-FRAC_W-1:0] src_x_o,
  output logic [2*dw_pkg::CODE_W+V_SHIFT-FRAC_W-1:0] src_y_o,
  output logic [dw_pkg::CODE_W-1:0]           pix_o
);
  localparam int unsigned COL_W  = CODE_W + H_SHIFT;
  localparam int unsigned ROW_W  = CODE_W + V_SHIFT;
  localparam int unsigned SRCX_W = COL_W + CODE_W - FRAC_W;
  localparam int unsigned SRCY_W = ROW_W + CODE_W - FRAC_W;
  localparam logic [COL_W-1:0] H_LAST = COL_W'(H_ACTIVE - 1);

  dw_cfg_t cfg_q;
  logic h_in, v_in, line_end;
  logic [SRCX_W-1:0] sx;
  logic [SRCY_W-1:0] sy;

  dw_regs #(
    .H_STOP_RST(H_ACTIVE >> H_SHIFT),
    .V_STOP_RST(V_ACTIVE >> V_SHIFT),
    .STEP_RST  (1 << FRAC_W)
  ) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .bank_sel_i, .wr_addr_i, .wr_data_i,
    .cfg_o(cfg_q)
  );

  assign line_end = pix_en_i && (col_i == H_LAST);

  dw_axis #(.SHIFT(H_SHIFT), .FRAC_W(FRAC_W)) i_haxis (
    .clk_i, .rst_ni,
    .adv_i(pix_en_i), .pos_i(col_i),
    .start_i(cfg_q.hstart), .stop_i(cfg_q.hstop), .step_i(cfg_q.hstep),
    .in_win_o(h_in), .src_o(sx)
  );

  dw_axis #(.SHIFT(V_SHIFT), .FRAC_W(FRAC_W)) i_vaxis (
    .clk_i, .rst_ni,
    .adv_i(line_end), .pos_i(row_i),
    .start_i(cfg_q.vstart), .stop_i(cfg_q.vstop), .step_i(cfg_q.vstep),
    .in_win_o(v_in), .src_o(sy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      src_x_o  <= '0;
      src_y_o  <= '0;
      pix_o    <= '0;
    end else if (pix_en_i) begin
      active_o <= h_in && v_in;
      src_x_o  <= sx;
      src_y_o  <= sy;
      pix_o    <= (h_in && v_in) ? layer_pix_i : cfg_q.border;
    end
  end
endmodule

// File: rtl/dw_window_chk.sv
module dw_window_chk #(
  parameter int unsigned COL_W   = 10,
  parameter int unsigned ROW_W   = 9,
  parameter int unsigned H_SHIFT = 2,
  parameter int unsigned V_SHIFT = 1,
  parameter int unsigned SRCX_W  = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pix_en_i,
  input logic [COL_W-1:0]  col_i,
  input logic [ROW_W-1:0]  row_i,
  input logic              active_o,
  input logic [7:0]        pix_o,
  input logic [SRCX_W-1:0] src_x_o,
  input logic [7:0]        border_i,
  input logic [7:0]        hstart_i,
  input logic [7:0]        hstop_i,
  input logic [7:0]        vstart_i,
  input logic [7:0]        vstop_i
);
  logic h_out, v_out;
  assign h_out = (col_i < {hstart_i, {H_SHIFT{1'b0}}}) || (col_i >= {hstop_i, {H_SHIFT{1'b0}}});
  assign v_out = (row_i < {vstart_i, {V_SHIFT{1'b0}}}) || (row_i >= {vstop_i, {V_SHIFT{1'b0}}});

  p_h_outside_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_i && h_out) |=> !active_o);

  p_v_outside_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_i && v_out) |=> !active_o);

  p_border_fill_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_i && (h_out || v_out)) |=> (pix_o == $past(border_i)));

  p_x_origin_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_i && col_i == {hstart_i, {H_SHIFT{1'b0}}}) |=> (src_x_o == '0));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> ($stable(active_o) && $stable(pix_o) && $stable(src_x_o)));
endmodule

bind disp_window dw_window_chk #(
  .COL_W(COL_W), .ROW_W(ROW_W), .H_SHIFT(H_SHIFT), .V_SHIFT(V_SHIFT), .SRCX_W(SRCX_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pix_en_i(pix_en_i),
  .col_i(col_i), .row_i(row_i),
  .active_o(active_o), .pix_o(pix_o), .src_x_o(src_x_o),
  .border_i(cfg_q.border), .hstart_i(cfg_q.hstart), .hstop_i(cfg_q.hstop),
  .vstart_i(cfg_q.vstart), .vstop_i(cfg_q.vstop)
);

// File: tb/test_disp_window.sv
`timescale 1ns/1ps
module test_disp_window;
  localparam int H = 64;
  localparam int V = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0, bank_sel_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic pix_en_i = 1'b0;
  logic [9:0] col_i = '0;
  logic [8:0] row_i = '0;
  logic [7:0] layer_pix_i = '0;
  logic active_o;
  logic [10:0] src_x_o;
  logic [9:0] src_y_o;
  logic [7:0] pix_o;

  int checks = 0, failures = 0;
  int m_hstep = 128, m_vstep = 128, m_border = 0;
  int m_hs = 0, m_he = H / 4, m_vs = 0, m_ve = V / 2;

  always #5 clk_i = ~clk_i;

  disp_window #(.H_ACTIVE(H), .V_ACTIVE(V)) i_disp_window (.*);

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(bit sel, int addr, int data);
    bank_sel_i = sel; wr_addr_i = 2'(addr); wr_data_i = 8'(data); wr_en_i = 1'b1;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic run_frame(output int n_act);
    n_act = 0;
    for (int r = 0; r < V; r++) begin
      for (int c = 0; c < H; c++) begin
        bit e_act;
        col_i = 10'(c); row_i = 9'(r); pix_en_i = 1'b1;
        layer_pix_i = 8'(c * 7 + r * 3 + 1);
        @(posedge clk_i); #1;
        e_act = (c >= 4 * m_hs) && (c < 4 * m_he) && (r >= 2 * m_vs) && (r < 2 * m_ve);
        check("R3 R4", "active_o", int'(active_o), int'(e_act));
        check("R5", "pix_o", int'(pix_o), e_act ? int'(layer_pix_i) : m_border);
        if (e_act) begin
          n_act++;
          check("R6", "src_x_o", int'(src_x_o), ((c - 4 * m_hs) * m_hstep) >> 7);
          check("R7", "src_y_o", int'(src_y_o), ((r - 2 * m_vs) * m_vstep) >> 7);
        end
      end
    end
    pix_en_i = 1'b0;
  endtask

  task automatic set_cfg(int hst, int vst, int bd, int hs, int he, int vs, int ve);
    wr(0, 0, hst); wr(0, 1, vst); wr(0, 2, bd);   // R2 bank 0 map
    wr(1, 0, hs);  wr(1, 1, he);  wr(1, 2, vs); wr(1, 3, ve);  // R2 bank 1 map
    m_hstep = hst; m_vstep = vst; m_border = bd;
    m_hs = hs; m_he = he; m_vs = vs; m_ve = ve;
  endtask

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, n_prev;
    logic s_act; logic [7:0] s_pix; logic [10:0] s_x; logic [9:0] s_y;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    // R1 reset state of outputs
    check("R1", "active_o reset", int'(active_o), 0);
    check("R1", "pix_o reset", int'(pix_o), 0);
    check("R1", "src_x_o reset", int'(src_x_o), 0);
    check("R1", "src_y_o reset", int'(src_y_o), 0);
    // R1 default window: every pixel active, unit step
    run_frame(n);
    check("R1", "active count default", n, H * V);

    // R8 outputs hold while pix_en_i low
    s_act = active_o; s_pix = pix_o; s_x = src_x_o; s_y = src_y_o;
    for (int k = 0; k < 3; k++) begin
      col_i = 10'(5 + k); row_i = 9'(9); layer_pix_i = 8'hEE;
      @(posedge clk_i); #1;
      check("R8", "active_o hold", int'(active_o), int'(s_act));
      check("R8", "pix_o hold", int'(pix_o), int'(s_pix));
      check("R8", "src_x_o hold", int'(src_x_o), int'(s_x));
      check("R8", "src_y_o hold", int'(src_y_o), int'(s_y));
    end

    // Offset window, half steps (pixel doubling)
    set_cfg(64, 64, 8'h5A, 2, 12, 3, 13);
    run_frame(n);
    check("R2", "active count offset", n, 40 * 20);
    n_prev = n;

    // R9: bank 0 slot 3 write ignored; frame must match previous configuration
    wr(0, 3, 8'hFF);
    run_frame(n);
    check("R9", "active count after ignored write", n, n_prev);

    // Step above 128, one row-pair tall window at the top
    set_cfg(200, 96, 8'hAB, 0, 16, 0, 1);
    run_frame(n);
    check("R4", "active count thin", n, 64 * 2);

    // Fractional step, window to the right edge
    set_cfg(37, 150, 8'h11, 5, 16, 4, 16);
    run_frame(n);
    check("R3", "active count right", n, 44 * 24);

    // Empty window: start beyond stop, all border
    set_cfg(128, 128, 8'hC3, 10, 5, 2, 14);
    run_frame(n);
    check("R5", "active count empty", n, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule